// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the clock enables of a small processor subsystem through a run state and three sleep levels. Software selects a level on a two-bit mode input and pulses an entry strobe. The controller then gates the CPU clock, the peripheral clocks and, at the deepest level, the oscillator and PLL. It brings them back when a wake source suited to that level appears.

The lightest level stops only the CPU clock. Each peripheral keeps its clock if its bit in a keep-alive mask is set, and an enabled interrupt from a peripheral that is still clocked ends the sleep. The middle level stops the CPU and all peripheral clocks while the oscillator and PLL keep running, and only an external interrupt wakes it. The deepest level also turns off the oscillator and PLL. Only reset or the non-maskable input ends it. After a non-maskable wake the oscillator is switched on again, and a programmable settle count must run out before any clock is released.

The block itself is assumed to run from an always-available reference clock. Oscillator start-up is modelled by the settle counter alone.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is low and after it is released, the block is in run mode: curMode is 0 and cpuClkEn, every periphClkEn bit, oscEn and pllEn are 1.
- R2: In run mode, an enterStb pulse with modeSel nonzero and no wake source active moves curMode to modeSel on the next clock. The encoding is 0 run, 1 idle, 2 standby, 3 halt. A strobe with modeSel 0 leaves the block in run mode.
- R3: In idle (curMode 1), cpuClkEn is 0, periphClkEn equals periphClkMask, and oscEn and pllEn are 1.
- R4: Idle ends on the next clock, returning to run mode, when any bit i has periphIrq[i], periphIrqEn[i] and periphClkMask[i] all set. An interrupt from a disabled or gated peripheral, extIrq and nmiIn leave idle unchanged.
- R5: In standby (curMode 2), cpuClkEn and all periphClkEn bits are 0 while oscEn and pllEn are 1. extIrq returns the block to run mode with all clocks enabled on the next clock. Peripheral interrupts and nmiIn are ignored.
- R6: In halt (curMode 3, before any non-maskable wake), cpuClkEn, periphClkEn, oscEn and pllEn are all 0. Peripheral interrupts and extIrq leave the block in halt.
- R7: nmiIn sampled in halt turns oscEn and pllEn on at the next clock. It keeps cpuClkEn and periphClkEn at 0, with curMode still 3, for settleCycles+1 clocks after the sampling edge, and then enters run mode. settleCycles is captured at the sampling edge.
- R8: An entry strobe given together with any wake source (an enabled peripheral interrupt, extIrq or nmiIn) is cancelled, and the block stays in run mode.
- R9: Asserting reset in any state, including the settle phase, forces run mode and all enables to 1 at once, without waiting for a clock edge.
- R10: An enterStb pulse while not in run mode has no effect on the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Requested mode: 0 run, 1 idle, 2 standby, 3 halt |
| enterStb | input | 1 | One-cycle request to enter modeSel |
| periphClkMask | input | NUM_PERIPH | Peripheral clocks kept on during idle |
| periphIrq | input | NUM_PERIPH | Peripheral interrupt requests |
| periphIrqEn | input | NUM_PERIPH | Peripheral interrupt enables |
| extIrq | input | 1 | External interrupt event |
| nmiIn | input | 1 | Non-maskable interrupt input |
| settleCycles | input | SETTLE_W | Oscillator settle count used after a halt wake |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | NUM_PERIPH | Per-peripheral clock enables |
| oscEn | output | 1 | Oscillator enable |
| pllEn | output | 1 | PLL enable |
| curMode | output | 2 | Current mode, same encoding as modeSel |

## Verification
The bench builds the controller with four peripherals and a four-bit settle count, so the widest settle value, 15, can be run to its end within a few cycles. Settle values of 0, 5 and 15 reach the shortest settle phase, a middle one and the counter's full range. The four peripherals allow masks in which one enabled interrupt sits on a gated peripheral and another on a clocked one.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_STBY,
    ST_HALT,
    ST_SETTLE
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } settleCmd_t;

  localparam logic [1:0] MODE_RUN  = 2'd0;
  localparam logic [1:0] MODE_IDLE = 2'd1;
  localparam logic [1:0] MODE_STBY = 2'd2;
  localparam logic [1:0] MODE_HALT = 2'd3;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            modeSel,
  input  logic                  enterStb,
  input  logic [NUM_PERIPH-1:0] periphClkMask,
  input  logic [NUM_PERIPH-1:0] periphIrq,
  input  logic [NUM_PERIPH-1:0] periphIrqEn,
  input  logic                  extIrq,
  input  logic                  nmiIn,
  input  logic                  cntZero,
  output settleCmd_t            cmd,
  output pwrState_e             state
);

  pwrState_e nextState;
  logic      idleWake;
  logic      entryWake;

  assign idleWake  = |(periphIrq & periphIrqEn & periphClkMask);
  assign entryWake = (|(periphIrq & periphIrqEn)) | extIrq | nmiIn;

  always_comb begin
    nextState   = state;
    cmd.loadCnt = 1'b0;
    cmd.decCnt  = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (enterStb && !entryWake) begin
          unique case (modeSel)
            MODE_IDLE: nextState = ST_IDLE;
            MODE_STBY: nextState = ST_STBY;
            MODE_HALT: nextState = ST_HALT;
            default:   nextState = ST_RUN;
          endcase
        end
      end
      ST_IDLE: if (idleWake) nextState = ST_RUN;
      ST_STBY: if (extIrq) nextState = ST_RUN;
      ST_HALT: begin
        if (nmiIn) begin
          nextState   = ST_SETTLE;
          cmd.loadCnt = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cntZero) nextState = ST_RUN;
        else         cmd.decCnt = 1'b1;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

endmodule

// File: rtl/pwr_clk_dp.sv
module pwr_clk_dp
  import pwr_mode_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int SETTLE_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  settleCmd_t            cmd,
  input  pwrState_e             state,
  input  logic [SETTLE_W-1:0]   settleCycles,
  input  logic [NUM_PERIPH-1:0] periphClkMask,
  output logic                  cntZero,
  output logic                  cpuClkEn,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  oscEn,
  output logic                  pllEn,
  output logic [1:0]            curMode
);

  localparam logic [NUM_PERIPH-1:0] ALL_ON  = '1;
  localparam logic [SETTLE_W-1:0]   CNT_ONE = SETTLE_W'(1);

  logic [SETTLE_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            settleCnt <= '0;
    else if (cmd.loadCnt) settleCnt <= settleCycles;
    else if (cmd.decCnt)  settleCnt <= settleCnt - CNT_ONE;
  end

  assign cntZero = (settleCnt == '0);

  always_comb begin
    cpuClkEn    = 1'b1;
    periphClkEn = ALL_ON;
    oscEn       = 1'b1;
    pllEn       = 1'b1;
    curMode     = MODE_RUN;
    unique case (state)
      ST_IDLE: begin
        cpuClkEn    = 1'b0;
        periphClkEn = periphClkMask;
        curMode     = MODE_IDLE;
      end
      ST_STBY: begin
        cpuClkEn    = 1'b0;
        periphClkEn = '0;
        curMode     = MODE_STBY;
      end
      ST_HALT: begin
        cpuClkEn    = 1'b0;
        periphClkEn = '0;
        oscEn       = 1'b0;
        pllEn       = 1'b0;
        curMode     = MODE_HALT;
      end
      ST_SETTLE: begin
        cpuClkEn    = 1'b0;
        periphClkEn = '0;
        curMode     = MODE_HALT;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int SETTLE_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            modeSel,
  input  logic                  enterStb,
  input  logic [NUM_PERIPH-1:0] periphClkMask,
  input  logic [NUM_PERIPH-1:0] periphIrq,
  input  logic [NUM_PERIPH-1:0] periphIrqEn,
  input  logic                  extIrq,
  input  logic                  nmiIn,
  input  logic [SETTLE_W-1:0]   settleCycles,
  output logic                  cpuClkEn,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  oscEn,
  output logic                  pllEn,
  output logic [1:0]            curMode
);

  settleCmd_t cmd;
  pwrState_e  state;
  logic       cntZero;

  pwr_mode_fsm #(.NUM_PERIPH(NUM_PERIPH)) u_fsm (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .enterStb(enterStb),
    .periphClkMask(periphClkMask), .periphIrq(periphIrq),
    .periphIrqEn(periphIrqEn), .extIrq(extIrq), .nmiIn(nmiIn),
    .cntZero(cntZero), .cmd(cmd), .state(state)
  );

  pwr_clk_dp #(.NUM_PERIPH(NUM_PERIPH), .SETTLE_W(SETTLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .state(state),
    .settleCycles(settleCycles), .periphClkMask(periphClkMask),
    .cntZero(cntZero), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .oscEn(oscEn), .pllEn(pllEn), .curMode(curMode)
  );

endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int NUM_PERIPH = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [1:0]            modeSel,
  input logic                  enterStb,
  input logic [NUM_PERIPH-1:0] periphClkMask,
  input logic [NUM_PERIPH-1:0] periphIrq,
  input logic [NUM_PERIPH-1:0] periphIrqEn,
  input logic                  extIrq,
  input logic                  nmiIn,
  input logic                  cpuClkEn,
  input logic [NUM_PERIPH-1:0] periphClkEn,
  input logic                  oscEn,
  input logic                  pllEn,
  input logic [1:0]            curMode
);

  // R1
  run_all_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd0) |-> (cpuClkEn && (&periphClkEn) && oscEn && pllEn));

  // R3
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd1) |-> (!cpuClkEn && periphClkEn == periphClkMask && oscEn));

  // R5
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd2 && !extIrq) |=> (curMode == 2'd2));

  // R6
  halt_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn) |-> (!pllEn && !cpuClkEn && periphClkEn == '0 && curMode == 2'd3));

  // R6
  halt_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && !nmiIn) |=> (!oscEn));

  // R7
  nmi_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && nmiIn) |=> (oscEn && pllEn && !cpuClkEn && curMode == 2'd3));

  // R8
  entry_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd0 && enterStb && (extIrq || nmiIn || (|(periphIrq & periphIrqEn))))
      |=> (curMode == 2'd0));

  // R10
  strobe_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd1 && enterStb && !(|(periphIrq & periphIrqEn & periphClkMask)))
      |=> (curMode == 2'd1));

endmodule

bind pwr_mode_ctl pwr_mode_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .enterStb(enterStb),
  .periphClkMask(periphClkMask), .periphIrq(periphIrq),
  .periphIrqEn(periphIrqEn), .extIrq(extIrq), .nmiIn(nmiIn),
  .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn),
  .pllEn(pllEn), .curMode(curMode)
);

// File: tb/sim_pwr_mode_ctl.sv
module sim_pwr_mode_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeSel = 2'd0;
  logic          enterStb = 1'b0;
  logic [NP-1:0] periphClkMask = '0;
  logic [NP-1:0] periphIrq = '0;
  logic [NP-1:0] periphIrqEn = '0;
  logic          extIrq = 1'b0;
  logic          nmiIn = 1'b0;
  logic [SW-1:0] settleCycles = '0;
  logic          cpuClkEn;
  logic [NP-1:0] periphClkEn;
  logic          oscEn;
  logic          pllEn;
  logic [1:0]    curMode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl #(.NUM_PERIPH(NP), .SETTLE_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .enterStb(enterStb),
    .periphClkMask(periphClkMask), .periphIrq(periphIrq),
    .periphIrqEn(periphIrqEn), .extIrq(extIrq), .nmiIn(nmiIn),
    .settleCycles(settleCycles), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .oscEn(oscEn), .pllEn(pllEn),
    .curMode(curMode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // packs {cpu, periph, osc, pll, mode}
  function automatic logic [31:0] outs();
    return {23'd0, cpuClkEn, periphClkEn, oscEn, pllEn, curMode};
  endfunction

  function automatic logic [31:0] mk(input logic c, input logic [NP-1:0] p,
                                     input logic o, input logic l, input logic [1:0] m);
    return {23'd0, c, p, o, l, m};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearIn();
    enterStb = 0; periphIrq = '0; periphIrqEn = '0; extIrq = 0; nmiIn = 0;
  endtask

  task automatic enterMode(input logic [1:0] m);
    modeSel = m; enterStb = 1;
    tick();
    enterStb = 0;
  endtask

  task automatic doReset();
    clearIn();
    rstN = 0;
    #1;
    chk("R1 in reset", outs(), mk(1, '1, 1, 1, 0));
    tick();
    rstN = 1;
    tick();
    chk("R1 after reset", outs(), mk(1, '1, 1, 1, 0));
  endtask

  task automatic testEntry();
    enterMode(2'd0);
    chk("R2 mode 0 strobe", outs(), mk(1, '1, 1, 1, 0));
    periphClkMask = 4'b0101;
    enterMode(2'd1);
    chk("R2 R3 idle entry", outs(), mk(0, 4'b0101, 1, 1, 1));
  endtask

  task automatic testIdleWake();
    // R4: irq on a gated peripheral (bit 1) and a disabled one (bit 2)
    periphIrqEn = 4'b0011; periphIrq = 4'b0110; extIrq = 1; nmiIn = 1;
    tick();
    chk("R4 ignored wakes", outs(), mk(0, 4'b0101, 1, 1, 1));
    clearIn();
    enterMode(2'd3);
    chk("R10 strobe in idle", {30'd0, curMode}, 32'd1);
    periphIrqEn = 4'b0101; periphIrq = 4'b0100;
    tick();
    chk("R4 idle wake", outs(), mk(1, '1, 1, 1, 0));
    clearIn();
  endtask

  task automatic testStandby();
    enterMode(2'd2);
    chk("R5 standby", outs(), mk(0, '0, 1, 1, 2));
    periphIrqEn = '1; periphIrq = '1; nmiIn = 1;
    tick();
    chk("R5 ignored wakes", outs(), mk(0, '0, 1, 1, 2));
    clearIn();
    extIrq = 1;
    tick();
    extIrq = 0;
    chk("R5 ext wake", outs(), mk(1, '1, 1, 1, 0));
  endtask

  task automatic testHalt(input logic [SW-1:0] s);
    settleCycles = s;
    enterMode(2'd3);
    chk("R6 halt", outs(), mk(0, '0, 0, 0, 3));
    periphIrqEn = '1; periphIrq = '1; extIrq = 1;
    tick();
    chk("R6 ignored wakes", outs(), mk(0, '0, 0, 0, 3));
    clearIn();
    nmiIn = 1;
    tick();
    nmiIn = 0;
    settleCycles = ~s;  // must not matter after capture
    chk("R7 osc on", outs(), mk(0, '0, 1, 1, 3));
    for (int k = 1; k <= int'(s); k++) begin
      tick();
      chk("R7 settling", outs(), mk(0, '0, 1, 1, 3));
    end
    tick();
    chk("R7 released", outs(), mk(1, '1, 1, 1, 0));
  endtask

  task automatic testCancel();
    modeSel = 2'd2; enterStb = 1; extIrq = 1;
    tick();
    chk("R8 cancel ext", {30'd0, curMode}, 32'd0);
    extIrq = 0; nmiIn = 1; modeSel = 2'd3;
    tick();
    chk("R8 cancel nmi", {30'd0, curMode}, 32'd0);
    nmiIn = 0; periphIrqEn = 4'b1000; periphIrq = 4'b1000; modeSel = 2'd1;
    tick();
    chk("R8 cancel periph", {30'd0, curMode}, 32'd0);
    clearIn();
  endtask

  task automatic testAsyncReset();
    settleCycles = 4'd9;
    enterMode(2'd3);
    nmiIn = 1;
    tick();
    nmiIn = 0;
    tick();
    #1;
    rstN = 0;
    #1;
    chk("R9 async reset", outs(), mk(1, '1, 1, 1, 0));
    tick();
    rstN = 1;
    tick();
    chk("R9 stays run", outs(), mk(1, '1, 1, 1, 0));
  endtask

  initial begin
    doReset();
    testEntry();
    testIdleWake();
    testStandby();
    testHalt(4'd0);
    testHalt(4'd5);
    testHalt(4'd15);
    testCancel();
    testAsyncReset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule